// File: doc/BRIEF.md
# Table-Controlled Bitslice ALU

This block is a purely combinational integer arithmetic and logic unit whose word width is a parameter (32 bits by default). Every operation runs through one shared datapath made of identical one-bit slices that are repeated across the word. Each slice holds a full adder, the basic logic gates, an optional inversion of operand B on its input and an optional inversion of its output on the far side of a result selector.

A 3-bit operation code goes into a small control table. The table returns the selector choice, the B-inversion flag, the carry into bit 0, the output-inversion flag and a flag that marks the arithmetic operations. Subtraction and signed compare reuse the adder with B inverted and a carry-in of 1. NOR reuses the OR path with the output inverted. Alongside the result the block reports a zero flag, a carry flag and a signed-overflow flag.

Because the width is a parameter, a 4-bit copy can be checked against every operand pair.

Top module: `tbs_alu`

## Requirements
- R1: Opcode 3'd0 (add) gives result = (A + B) mod 2^W, and carry_o is bit W of the unsigned sum A + B.
- R2: Opcode 3'd1 (subtract) gives result = (A - B) mod 2^W, formed as A + ~B + 1. carry_o is bit W of that sum, so it is 1 exactly when A >= B unsigned.
- R3: For add and subtract, ovf_o is 1 exactly when the signed result does not fit in W bits. This equals the XOR of the carry into and the carry out of the top slice.
- R4: Opcode 3'd3 (set-less-than) gives result bit 0 = 1 when A < B as two's-complement numbers, and all other result bits 0.
- R5: Opcode 3'd2 gives the bitwise XOR of A and B.
- R6: Opcode 3'd4 gives the bitwise AND of A and B.
- R7: Opcode 3'd5 gives the bitwise NOR of A and B.
- R8: Opcode 3'd6 gives the bitwise OR of A and B.
- R9: Opcode 3'd7 gives an all-zero result for any operands.
- R10: zero_o is 1 exactly when every result bit is 0, for every opcode.
- R11: For every opcode other than 3'd0 and 3'd1, carry_o and ovf_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | W | Operand A |
| b_i | input | W | Operand B |
| op_i | input | 3 | Operation code |
| result_o | output | W | Operation result |
| zero_o | output | 1 | High when the result is all zeros |
| carry_o | output | 1 | Carry out of the top slice (add/subtract only) |
| ovf_o | output | 1 | Signed overflow (add/subtract only) |

## Verification
The assertions are evaluated whenever an input changes, and they compare the output ports with arithmetic results computed at the port level. They cover the sum and carry of add, the difference and no-borrow carry of subtract, the signed overflow rule, the single-bit form of the compare result, the four logic operations, the zero result of the spare opcode, and the silenced flags outside arithmetic. Two things can only be shown by the bench's scenarios. The first is that the carry chain works at the word boundaries, which the bench covers by sweeping every operand pair at 4 bits. The second is that the signed corner operands (most-negative, most-positive, all ones) give the right overflow and compare results at 32 bits.

// File: rtl/tbs_alu_pkg.sv
package tbs_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_XOR = 3'd2,
    OP_SLT = 3'd3,
    OP_AND = 3'd4,
    OP_NOR = 3'd5,
    OP_OR  = 3'd6,
    OP_NUL = 3'd7
  } alu_op_e;

  typedef enum logic [2:0] {
    PICK_SUM  = 3'd0,
    PICK_XOR  = 3'd1,
    PICK_AND  = 3'd2,
    PICK_OR   = 3'd3,
    PICK_LESS = 3'd4,
    PICK_NONE = 3'd5
  } pick_e;

  typedef struct packed {
    pick_e pick;
    logic  flip_b;
    logic  carry_seed;
    logic  flip_out;
    logic  arith;
  } alu_ctrl_t;

endpackage

// File: rtl/tbs_alu_ctrl_lut.sv
module tbs_alu_ctrl_lut
  import tbs_alu_pkg::*;
(
  input  logic [2:0] op_i,
  output alu_ctrl_t  ctrl_o
);

  always_comb begin
    ctrl_o = '{pick: PICK_NONE, flip_b: 1'b0, carry_seed: 1'b0,
               flip_out: 1'b0, arith: 1'b0};
    unique case (alu_op_e'(op_i))
      OP_ADD: ctrl_o = '{PICK_SUM,  1'b0, 1'b0, 1'b0, 1'b1};
      OP_SUB: ctrl_o = '{PICK_SUM,  1'b1, 1'b1, 1'b0, 1'b1};
      OP_XOR: ctrl_o = '{PICK_XOR,  1'b0, 1'b0, 1'b0, 1'b0};
      OP_SLT: ctrl_o = '{PICK_LESS, 1'b1, 1'b1, 1'b0, 1'b0};
      OP_AND: ctrl_o = '{PICK_AND,  1'b0, 1'b0, 1'b0, 1'b0};
      OP_NOR: ctrl_o = '{PICK_OR,   1'b0, 1'b0, 1'b1, 1'b0};
      OP_OR:  ctrl_o = '{PICK_OR,   1'b0, 1'b0, 1'b0, 1'b0};
      OP_NUL: ctrl_o = '{PICK_NONE, 1'b0, 1'b0, 1'b0, 1'b0};
      default: ;
    endcase
  end

endmodule

// File: rtl/tbs_alu_slice.sv
module tbs_alu_slice
  import tbs_alu_pkg::*;
(
  input  logic      a_i,
  input  logic      b_i,
  input  logic      cin_i,
  input  logic      less_i,
  input  alu_ctrl_t ctrl_i,
  output logic      sum_o,
  output logic      cout_o,
  output logic      res_o
);

  logic bx;
  logic prop;
  logic picked;

  assign bx     = b_i ^ ctrl_i.flip_b;
  assign prop   = a_i ^ bx;
  assign sum_o  = prop ^ cin_i;
  assign cout_o = (a_i & bx) | (cin_i & prop);

  always_comb begin
    unique case (ctrl_i.pick)
      PICK_SUM:  picked = sum_o;
      PICK_XOR:  picked = prop;
      PICK_AND:  picked = a_i & bx;
      PICK_OR:   picked = a_i | bx;
      PICK_LESS: picked = less_i;
      default:   picked = 1'b0;
    endcase
  end

  assign res_o = picked ^ ctrl_i.flip_out;

endmodule

// File: rtl/tbs_alu.sv
module tbs_alu
  import tbs_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [2:0]   op_i,
  output logic [W-1:0] result_o,
  output logic         zero_o,
  output logic         carry_o,
  output logic         ovf_o
);

  localparam int MSB = W - 1;

  alu_ctrl_t     ctrl;
  logic [W:0]    chain;
  logic [MSB:0]  sum;
  logic [MSB:0]  res;
  logic          ovf_raw;
  logic          less;

  tbs_alu_ctrl_lut u_lut (
    .op_i   (op_i),
    .ctrl_o (ctrl)
  );

  assign chain[0] = ctrl.carry_seed;
  assign ovf_raw  = chain[W] ^ chain[MSB];
  assign less     = sum[MSB] ^ ovf_raw;

  for (genvar i = 0; i < W; i++) begin : g_slice
    logic less_in;
    if (i == 0) begin : g_lsb
      assign less_in = less;
    end else begin : g_upper
      assign less_in = 1'b0;
    end
    tbs_alu_slice u_slice (
      .a_i    (a_i[i]),
      .b_i    (b_i[i]),
      .cin_i  (chain[i]),
      .less_i (less_in),
      .ctrl_i (ctrl),
      .sum_o  (sum[i]),
      .cout_o (chain[i+1]),
      .res_o  (res[i])
    );
  end

  assign result_o = res;
  assign zero_o   = ~|res;
  assign carry_o  = ctrl.arith & chain[W];
  assign ovf_o    = ctrl.arith & ovf_raw;

endmodule

// File: rtl/tbs_alu_chk.sv
module tbs_alu_chk #(
  parameter int W = 32
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [2:0]   op_i,
  input logic [W-1:0] result_o,
  input logic         zero_o,
  input logic         carry_o,
  input logic         ovf_o
);

  logic [W:0] add_full;
  logic [W:0] sub_full;
  logic       sa;
  logic       sb;
  logic       sr;

  assign add_full = {1'b0, a_i} + {1'b0, b_i};
  assign sub_full = {1'b0, a_i} + {1'b0, ~b_i} + {{W{1'b0}}, 1'b1};
  assign sa = a_i[W-1];
  assign sb = b_i[W-1];
  assign sr = result_o[W-1];

  always_comb begin
    if (op_i == 3'd0) begin
      p_add_sum_r1: assert ({carry_o, result_o} == add_full);
      p_add_ovf_r3: assert (ovf_o == ((sa == sb) && (sr != sa)));
    end
    if (op_i == 3'd1) begin
      p_sub_diff_r2: assert ({carry_o, result_o} == sub_full);
      p_sub_ovf_r3: assert (ovf_o == ((sa != sb) && (sr != sa)));
    end
    if (op_i == 3'd3)
      p_slt_value_r4: assert (result_o == W'($signed(a_i) < $signed(b_i)));
    if (op_i == 3'd2) p_xor_r5: assert (result_o == (a_i ^ b_i));
    if (op_i == 3'd4) p_and_r6: assert (result_o == (a_i & b_i));
    if (op_i == 3'd5) p_nor_r7: assert (result_o == ~(a_i | b_i));
    if (op_i == 3'd6) p_or_r8:  assert (result_o == (a_i | b_i));
    if (op_i == 3'd7) p_null_r9: assert (result_o == '0);
    p_zero_flag_r10: assert (zero_o == (result_o == '0));
    if (op_i > 3'd1)
      p_flags_quiet_r11: assert (!carry_o && !ovf_o);
  end

endmodule

bind tbs_alu tbs_alu_chk #(.W(W)) u_chk (
  .a_i      (a_i),
  .b_i      (b_i),
  .op_i     (op_i),
  .result_o (result_o),
  .zero_o   (zero_o),
  .carry_o  (carry_o),
  .ovf_o    (ovf_o)
);

// File: tb/tbs_alu_tb.sv
module tbs_alu_tb_top;

  logic clk;
  logic rst_n;
  int   checks;
  int   failures;
  bit   done;

  logic [31:0] a32, b32, r32;
  logic [3:0]  a4, b4, r4;
  logic [2:0]  op32, op4;
  logic        z32, c32, v32, z4, c4, v4;

  tbs_alu #(.W(32)) dut_i (
    .a_i(a32), .b_i(b32), .op_i(op32),
    .result_o(r32), .zero_o(z32), .carry_o(c32), .ovf_o(v32)
  );

  tbs_alu #(.W(4)) dut4_i (
    .a_i(a4), .b_i(b4), .op_i(op4),
    .result_o(r4), .zero_o(z4), .carry_o(c4), .ovf_o(v4)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R5";
      3'd3: return "R4";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic compare(input int w, input logic [63:0] a, input logic [63:0] b,
                         input logic [2:0] op, input logic [63:0] r,
                         input logic z, input logic c, input logic v);
    logic [63:0] mask, er, full;
    logic ec, ev, ez, sa, sb;
    longint sai, sbi;
    mask = (64'd1 << w) - 64'd1;
    a &= mask; b &= mask; r &= mask;
    sa = a[w-1]; sb = b[w-1];
    sai = sa ? longint'(a) - (longint'(1) << w) : longint'(a);
    sbi = sb ? longint'(b) - (longint'(1) << w) : longint'(b);
    ec = 1'b0; ev = 1'b0;
    case (op)
      3'd0: begin
        full = a + b; er = full & mask; ec = full[w];
        ev = (sa == sb) && (er[w-1] != sa);
      end
      3'd1: begin
        full = a + ((~b) & mask) + 64'd1; er = full & mask; ec = full[w];
        ev = (sa != sb) && (er[w-1] != sa);
      end
      3'd2: er = a ^ b;
      3'd3: er = (sai < sbi) ? 64'd1 : 64'd0;
      3'd4: er = a & b;
      3'd5: er = (~(a | b)) & mask;
      3'd6: er = a | b;
      default: er = 64'd0;
    endcase
    ez = (er == 64'd0);
    checks++;
    if (r !== er) begin
      failures++;
      $display("FAIL %s w=%0d op=%0d a=%h b=%h result actual=%h expected=%h",
               tag_of(op), w, op, a, b, r, er);
    end else if (z !== ez) begin
      failures++;
      $display("FAIL R10 w=%0d op=%0d zero actual=%b expected=%b", w, op, z, ez);
    end else if (c !== ec || v !== ev) begin
      failures++;
      $display("FAIL %s w=%0d op=%0d a=%h b=%h carry/ovf actual=%b%b expected=%b%b",
               (op < 3'd2) ? ((op == 3'd0) ? "R1/R3" : "R2/R3") : "R11",
               w, op, a, b, c, v, ec, ev);
    end
  endtask

  task automatic apply32(input logic [31:0] a, input logic [31:0] b, input logic [2:0] op);
    @(posedge clk);
    #1 a32 = a; b32 = b; op32 = op;
    @(negedge clk);
    compare(32, {32'd0, a32}, {32'd0, b32}, op32, {32'd0, r32}, z32, c32, v32);
  endtask

  task automatic apply4(input logic [3:0] a, input logic [3:0] b, input logic [2:0] op);
    @(posedge clk);
    #1 a4 = a; b4 = b; op4 = op;
    @(negedge clk);
    compare(4, {60'd0, a4}, {60'd0, b4}, op4, {60'd0, r4}, z4, c4, v4);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] corner [5];
    checks = 0; failures = 0; done = 1'b0;
    a32 = '0; b32 = '0; op32 = 3'd0;
    a4 = '0; b4 = '0; op4 = 3'd0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Idle state: add of zeros gives zero result, zero flag set (R1, R10)
    @(negedge clk);
    compare(32, 64'd0, 64'd0, 3'd0, {32'd0, r32}, z32, c32, v32);

    // Exhaustive sweep at width 4 over every opcode (R1..R11)
    for (int op = 0; op < 8; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          apply4(4'(a), 4'(b), 3'(op));

    // Corner operands at width 32: overflow and signed compare (R3, R4)
    corner[0] = 32'h0000_0000;
    corner[1] = 32'hFFFF_FFFF;
    corner[2] = 32'h8000_0000;
    corner[3] = 32'h7FFF_FFFF;
    corner[4] = 32'h0000_0001;
    for (int op = 0; op < 8; op++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          apply32(corner[i], corner[j], 3'(op));

    // Random operands at width 32 (R1..R11)
    for (int n = 0; n < 400; n++)
      apply32($urandom, $urandom, 3'(n % 8));

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule